// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture

This block stamps the transitions of an external signal with the value of a free-running binary counter. The input is brought into the clock domain through a two-flop synchroniser. It can then be slowed by a programmable even divider. After that, the qualified edges are dealt out in turn to four capture slots. Each slot chooses its own edge direction. Each slot can also clear the counter once its timestamp has been taken, so the next slot measures a relative interval directly.

A small sequencer holds the index of the slot that waits for the next edge. In continuous mode it cycles through slots 1 to K and returns to slot 1, where K is chosen by software. In one-shot mode it stops after slot K and ignores every later edge until software re-arms it. A typical use is period measurement: set one-shot mode, stop after slot 2, clear the counter on slot 2, and read the period as CAP2 minus CAP1.

Every slot that fires produces a one-cycle pulse on its own output line. A separate pulse marks a counter wrap. Configuration and readback go through a simple write port and a combinational read port.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset, both control words, all four capture registers and the output pulses are zero.
- R2: The counter rises by one on every clock and wraps from all-ones to zero. In the cycle where it reads zero after such a wrap, `ovf_pulse` is high for exactly one cycle. A software write to the counter (address 2) loads the written value, and counting continues from that value on the next clock.
- R3: Control word A bit k (k = 0..3) selects the edge for slot k+1: 0 means rising, 1 means falling. The selection acts on the signal after the divider.
- R4: Control word A bit 4+k enables a counter clear for slot k+1. The slot stores the counter value of its capture cycle, and the counter reads zero in the next cycle. A clear that falls in the same cycle as the counter reaching all-ones takes precedence, and no overflow pulse is raised.
- R5: Control word A bits [12:8] hold the prescale value N. N = 0 passes the synchronised input straight through. For N of 1 or more, the input is divided by 2N, so consecutive qualified rising edges lie 2N input periods apart.
- R6: A timestamp is loaded only when both the load enable (control word A bit 13) and the capture mode bit (control word B bit 4) are 1. Otherwise the capture registers keep their values, while the slot pulses still appear.
- R7: In continuous mode (control word B bit 0 = 0), slots fire in the order 1, 2, … up to slot S+1, where S is control word B bits [2:1]. The sequence then returns to slot 1. Slots above S+1 never load.
- R8: In one-shot mode (control word B bit 0 = 1), after slot S+1 fires the sequencer freezes. Later edges produce no pulse and no load.
- R9: Writing 1 to control word B bit 3 returns the sequencer to slot 1 and unfreezes it. That bit always reads as 0.
- R10: `evt_pulse` is one-hot or zero. Bit k pulses for one cycle when slot k+1 fires. That cycle is the first one in which the new capture value can be read.
- R11: Read map: address 0 is control word A, 1 is control word B, 2 is the counter (also writable), 4 to 7 are CAP1 to CAP4 (read-only). Address 3 reads 0.
- R12: A level change on `sig_in` that is present at clock edge k (no prescale) is captured at edge k+2, with the counter value held in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| sig_in | input | 1 | Asynchronous signal whose edges are stamped |
| evt_pulse | output | 4 | One-cycle pulse per capture slot |
| ovf_pulse | output | 1 | One-cycle pulse after a counter wrap |

## Verification
A slot clear and the counter's natural wrap can land on the same clock. To provoke this, the bench writes all-ones minus one into the counter on the same clock edge where it raises `sig_in`, with slot 1 set to rising edge and counter clear. Because the synchroniser latency is fixed, the capture then happens exactly when the counter holds all-ones. The bench expects CAP1 to read all-ones, the slot-1 pulse to appear, the counter to read zero in that cycle, and no overflow pulse at all.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int NSLOT  = 4;
  localparam int SEQ_W  = $clog2(NSLOT);
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL_A = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL_B = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd2;

  // control word B bit positions
  localparam int B_ONESHOT = 0;
  localparam int B_STOP_LO = 1;
  localparam int B_REARM   = 3;
  localparam int B_CAPMODE = 4;

  // slot that follows cur, wrapping after the programmed last slot
  function automatic logic [SEQ_W-1:0] slot_after(input logic [SEQ_W-1:0] cur,
                                                  input logic [SEQ_W-1:0] last);
    return (cur == last) ? '0 : cur + 1'b1;
  endfunction

  // divider terminal test: >= so a shrinking N never skips its terminal count
  function automatic logic div_terminal(input logic [7:0] cnt, input logic [7:0] n);
    return cnt >= (n - 8'd1);
  endfunction
endpackage

// File: rtl/esc_input_cond.sv
module esc_input_cond #(
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [PSC_W-1:0] psc,
  output logic             rise,
  output logic             fall
);
  import esc_pkg::*;

  logic             sync1, sync2, sync2_d;
  logic             div_q, qual_d;
  logic [PSC_W-1:0] div_cnt;
  logic             bypass, qual, in_rise;

  assign bypass  = (psc == '0);
  assign in_rise = sync2 & ~sync2_d;
  assign qual    = bypass ? sync2 : div_q;
  assign rise    = qual & ~qual_d;
  assign fall    = ~qual & qual_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      sync2_d <= 1'b0;
      qual_d  <= 1'b0;
      div_q   <= 1'b0;
      div_cnt <= '0;
    end else begin
      sync1   <= sig_in;
      sync2   <= sync1;
      sync2_d <= sync2;
      qual_d  <= qual;
      if (bypass) begin
        div_cnt <= '0;
      end else if (in_rise) begin
        if (div_terminal(8'(div_cnt), 8'(psc))) begin
          div_cnt <= '0;
          div_q   <= ~div_q;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !in_rise) |=> $stable(div_q));
endmodule

// File: rtl/esc_sequencer.sv
module esc_sequencer (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rise,
  input  logic                              fall,
  input  logic [esc_pkg::NSLOT-1:0]         pol,
  input  logic                              one_shot,
  input  logic [esc_pkg::SEQ_W-1:0]         last_slot,
  input  logic                              rearm,
  output logic [esc_pkg::SEQ_W-1:0]         slot,
  output logic                              frozen,
  output logic                              fire,
  output logic [esc_pkg::NSLOT-1:0]         evt_q
);
  import esc_pkg::*;

  logic qualified;

  assign qualified = pol[slot] ? fall : rise;
  assign fire      = qualified & ~frozen & ~rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      frozen <= 1'b0;
      evt_q  <= '0;
    end else begin
      evt_q <= fire ? (NSLOT'(1) << slot) : '0;
      if (rearm) begin
        slot   <= '0;
        frozen <= 1'b0;
      end else if (fire) begin
        if (one_shot && slot == last_slot) frozen <= 1'b1;
        else                               slot   <= slot_after(slot, last_slot);
      end
    end
  end

  // R10
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_q));
  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rearm) |=> (frozen && $stable(slot) && evt_q == '0));
  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (slot == '0 && !frozen));
endmodule

// File: rtl/esc_timebase.sv
module esc_timebase #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      ovf <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      ovf <= &cnt;
    end
  end

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> (cnt == '0 && !ovf));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R2
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cnt == '0);
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [esc_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]          wr_data,
  input  logic [esc_pkg::ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]          rd_data,
  input  logic                      sig_in,
  output logic [esc_pkg::NSLOT-1:0] evt_pulse,
  output logic                      ovf_pulse
);
  import esc_pkg::*;

  localparam int RST_LO = NSLOT;
  localparam int PSC_LO = 2 * NSLOT;
  localparam int LD_BIT = PSC_LO + PSC_W;

  logic [NSLOT-1:0] pol_r, rst_en_r;
  logic [PSC_W-1:0] psc_r;
  logic             load_en_r, one_shot_r, cap_mode_r;
  logic [SEQ_W-1:0] last_r;

  logic             wr_a, wr_b, wr_cnt, rearm;
  logic             rise, fall, fire, frozen, cnt_clr;
  logic [SEQ_W-1:0] slot;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap_q [NSLOT];
  logic [NSLOT-1:0] cap_load;

  assign wr_a    = wr_en && wr_addr == ADR_CTRL_A;
  assign wr_b    = wr_en && wr_addr == ADR_CTRL_B;
  assign wr_cnt  = wr_en && wr_addr == ADR_COUNT;
  assign rearm   = wr_b && wr_data[B_REARM];
  assign cnt_clr = fire && rst_en_r[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_r      <= '0;
      rst_en_r   <= '0;
      psc_r      <= '0;
      load_en_r  <= 1'b0;
      one_shot_r <= 1'b0;
      last_r     <= '0;
      cap_mode_r <= 1'b0;
    end else begin
      if (wr_a) begin
        pol_r     <= wr_data[NSLOT-1:0];
        rst_en_r  <= wr_data[RST_LO +: NSLOT];
        psc_r     <= wr_data[PSC_LO +: PSC_W];
        load_en_r <= wr_data[LD_BIT];
      end
      if (wr_b) begin
        one_shot_r <= wr_data[B_ONESHOT];
        last_r     <= wr_data[B_STOP_LO +: SEQ_W];
        cap_mode_r <= wr_data[B_CAPMODE];
      end
    end
  end

  esc_input_cond #(.PSC_W(PSC_W)) cond_i (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .psc(psc_r),
    .rise(rise), .fall(fall)
  );

  esc_sequencer seq_i (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .pol(pol_r),
    .one_shot(one_shot_r), .last_slot(last_r), .rearm(rearm),
    .slot(slot), .frozen(frozen), .fire(fire), .evt_q(evt_pulse)
  );

  esc_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(wr_data),
    .clr(cnt_clr), .cnt(cnt), .ovf(ovf_pulse)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_cap
    assign cap_load[k] = fire && slot == SEQ_W'(k) && load_en_r && cap_mode_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cap_q[k] <= '0;
      else if (cap_load[k]) cap_q[k] <= cnt;
    end

    // R6
    cap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_load[k] |=> cap_q[k] == $past(cnt));
    // R6
    cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_load[k] |=> $stable(cap_q[k]));
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL_A: rd_data = CNT_W'({load_en_r, psc_r, rst_en_r, pol_r});
      ADR_CTRL_B: rd_data = CNT_W'({cap_mode_r, 1'b0, last_r, one_shot_r});
      ADR_COUNT:  rd_data = cnt;
      default: if (rd_addr[ADDR_W-1]) rd_data = cap_q[rd_addr[SEQ_W-1:0]];
    endcase
  end

  // R9
  rearm_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADR_CTRL_B) |-> !rd_data[B_REARM]);
endmodule

// File: tb/edge_stamp_capture_tb_top.sv
module edge_stamp_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sig_in = 1'b0;
  logic [3:0]  evt_pulse;
  logic        ovf_pulse;

  int n_chk = 0, n_err = 0;
  int evt_seen [4] = '{0, 0, 0, 0};
  int ovf_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edge_stamp_capture dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sig_in(sig_in),
    .evt_pulse(evt_pulse), .ovf_pulse(ovf_pulse)
  );

  always @(negedge clk) if (rst_n) begin
    for (int k = 0; k < 4; k++) if (evt_pulse[k]) evt_seen[k]++;
    if (ovf_pulse) ovf_seen++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_a(int pol, int rst, int psc, int ld);
    return 32'((ld << 13) | (psc << 8) | (rst << 4) | pol);
  endfunction

  function automatic logic [31:0] cfg_b(int cm, int rearm, int stop, int os);
    return 32'((cm << 4) | (rearm << 3) | (stop << 1) | os);
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a; #2 v = rd_data;
  endtask

  task automatic wave(int hi, int lo, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sig_in = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk); sig_in = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  task automatic caps(output logic [31:0] c [4]);
    repeat (6) @(negedge clk);
    for (int k = 0; k < 4; k++) rd(3'(4 + k), c[k]);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c [4], prev [4];
    int snap [4];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 map
    check("R1 evt_pulse", 32'(evt_pulse), 0);
    check("R1 ovf_pulse", 32'(ovf_pulse), 0);
    rd(3'd0, v); check("R1 ctrl A", v, 0);
    rd(3'd1, v); check("R1 ctrl B", v, 0);
    for (int k = 0; k < 4; k++) begin rd(3'(4 + k), v); check("R1 cap", v, 0); end
    rd(3'd3, v); check("R11 unused addr", v, 0);

    // R7 R8 R10 one-shot four slots, rising edges, period sweep
    foreach (snap[k]) snap[k] = 0;
    for (int p = 6; p <= 30; p += 8) begin
      wr(3'd0, cfg_a(0, 0, 0, 1));
      wr(3'd1, cfg_b(1, 1, 3, 1));
      foreach (snap[k]) snap[k] = evt_seen[k];
      wave(p / 2, p - p / 2, 8);
      caps(c);
      for (int k = 1; k < 4; k++) check("R7 slot delta", c[k] - c[k-1], 32'(p));
      for (int k = 0; k < 4; k++) check("R10 one pulse per slot", 32'(evt_seen[k] - snap[k]), 1);
    end
    rd(3'd1, v); check("R11 ctrl B readback", v, cfg_b(1, 0, 3, 1));

    // R3 per-slot polarity
    wr(3'd0, cfg_a(4'b1010, 0, 0, 1));
    wr(3'd1, cfg_b(1, 1, 3, 1));
    wave(7, 12, 6); caps(c);
    check("R3 rise->fall", c[1] - c[0], 7);
    check("R3 fall->rise", c[2] - c[1], 12);
    check("R3 rise->fall 2", c[3] - c[2], 7);
    wr(3'd0, cfg_a(4'b0101, 0, 0, 1));
    wr(3'd1, cfg_b(1, 1, 3, 1));
    wave(7, 12, 6); caps(c);
    check("R3 fall->rise first", c[1] - c[0], 12);
    check("R3 rise->fall second", c[2] - c[1], 7);

    // R5 prescale sweep
    for (int n = 1; n <= 4; n++) begin
      wr(3'd0, cfg_a(0, 0, n, 1));
      wr(3'd1, cfg_b(1, 1, 1, 1));
      wave(3, 3, 8 * n + 2); caps(c);
      check("R5 divided interval", c[1] - c[0], 32'(2 * n * 6));
    end
    rd(3'd0, v); check("R11 ctrl A readback", v, cfg_a(0, 0, 4, 1));

    // R4 R7 continuous wrap after slot 2, clear on slot 2
    wr(3'd0, cfg_a(0, 4'b0010, 0, 1));
    wr(3'd1, cfg_b(1, 1, 1, 0));
    rd(3'd6, prev[2]);
    foreach (snap[k]) snap[k] = evt_seen[k];
    wave(4, 5, 6); caps(c);
    check("R4 stamp after clear", c[0], 8);
    check("R4 second stamp", c[1], 17);
    check("R7 slot3 untouched", c[2], prev[2]);
    check("R7 slot1 pulses", 32'(evt_seen[0] - snap[0]), 3);
    check("R7 slot3 pulses", 32'(evt_seen[2] - snap[2]), 0);

    // R8 R9 freeze and re-arm
    wr(3'd0, cfg_a(0, 0, 0, 1));
    wr(3'd1, cfg_b(1, 1, 1, 1));
    wave(5, 5, 2); caps(prev);
    check("R8 first interval", prev[1] - prev[0], 10);
    foreach (snap[k]) snap[k] = evt_seen[k];
    wave(4, 4, 3); caps(c);
    check("R8 frozen no pulse", 32'(evt_seen[0] + evt_seen[1] - snap[0] - snap[1]), 0);
    check("R8 frozen CAP1", c[0], prev[0]);
    check("R8 frozen CAP2", c[1], prev[1]);
    rd(3'd1, v); check("R9 rearm reads 0", 32'(v[3]), 0);
    wr(3'd1, cfg_b(1, 1, 1, 1));
    wave(7, 7, 2); caps(c);
    check("R9 rearmed interval", c[1] - c[0], 14);

    // R6 load gating
    wr(3'd0, cfg_a(0, 0, 0, 0));
    wr(3'd1, cfg_b(1, 1, 3, 0));
    for (int k = 0; k < 4; k++) rd(3'(4 + k), prev[k]);
    foreach (snap[k]) snap[k] = evt_seen[k];
    wave(5, 5, 4); caps(c);
    for (int k = 0; k < 4; k++) check("R6 no load when disabled", c[k], prev[k]);
    for (int k = 0; k < 4; k++) check("R6 pulses kept", 32'(evt_seen[k] - snap[k]), 1);
    wr(3'd0, cfg_a(0, 0, 0, 1));
    wr(3'd1, cfg_b(0, 1, 3, 0));
    wave(5, 5, 4); caps(c);
    for (int k = 0; k < 4; k++) check("R6 no load outside capture mode", c[k], prev[k]);

    // R2 counter write, count and wrap
    wr(3'd2, 32'd100);
    rd(3'd2, v); check("R2 write then count", v, 101);
    snap[0] = ovf_seen;
    wr(3'd2, 32'hFFFF_FFF0);
    repeat (30) @(negedge clk);
    check("R2 one overflow pulse", 32'(ovf_seen - snap[0]), 1);
    rd(3'd2, v); check("R2 wrapped count small", 32'(v < 40 && v > 0), 1);

    // R4 R12 clear on the same clock the counter reaches all-ones
    wr(3'd0, cfg_a(0, 4'b0001, 0, 1));
    wr(3'd1, cfg_b(1, 1, 0, 0));
    repeat (4) @(negedge clk);
    snap[0] = ovf_seen;
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'hFFFF_FFFE; sig_in = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk); rd_addr = 3'd2; #2;
    check("R12 counter cleared at capture", rd_data, 0);
    check("R10 slot1 pulse with capture", 32'(evt_pulse), 1);
    rd(3'd4, v); check("R12 stamp all-ones", v, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    check("R4 clear beats overflow", 32'(ovf_seen - snap[0]), 0);
    sig_in = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule